// File: doc/BRIEF.md
# Receive FIFO with Fill Status and Stale-Data Time-out

This block is the receive-side word buffer of a serial peripheral controller. The serial shifter hands it complete words on a write port, and software takes them out through a read port. The block keeps the words in arrival order and reports how many it holds. It shows live full and empty indications, and a threshold indication that is high only while the fill count is strictly above a programmed level. An interrupt request follows that threshold indication when its enable is set.

Two sticky event flags are kept, and each is cleared by a one-cycle clear pulse (write-one-to-clear). An overrun flag records that a word arrived while the buffer was full and was thrown away. A time-out flag records that data sat unread too long. In master operation the wait is measured in serial-clock ticks. In slave operation it is measured in engine clock cycles. A software read also clears the time-out flag automatically.

Top module: `rx_fifo_status`

## Requirements
- R1: After reset, `count_o` is 0, `empty_o` is 1, and `full_o`, `thr_flag_o`, `ovr_flag_o`, `to_flag_o` and `irq_o` are 0.
- R2: Words are returned in write order. The head word is always visible on `rd_data_o`, and a read pulse removes it. `count_o` gives the number of stored words (0 to 8). `full_o` is 1 exactly at 8 words and `empty_o` is 1 exactly at 0 words.
- R3: `thr_flag_o` is 1 while `count_o` > `thr_level_i` (strictly greater) and 0 otherwise. It is not sticky and follows the count.
- R4: `irq_o` is 1 exactly when `thr_flag_o` and `thr_ie_i` are both 1.
- R5: A write while full, without a read in the same cycle, is discarded and sets `ovr_flag_o` on the next edge. The flag stays set until a cycle with `ovr_clr_i`=1 and no new overrun. A new overrun wins over a clear in the same cycle.
- R6: A read and a write in the same cycle while full are both accepted. The count stays 8 and no overrun is flagged.
- R7: With `slave_mode_i`=0 (master), `to_flag_o` sets when the buffer has stayed non-empty and unread for 64 cycles with `sclk_tick_i`=1. Cycles without a tick do not advance the wait.
- R8: With `slave_mode_i`=1 (slave), `to_flag_o` sets when the buffer has stayed non-empty and unread for 576 clock cycles.
- R9: `to_flag_o` clears on the edge of an accepted read or of a `to_clr_i` pulse. An accepted read, or the buffer becoming empty, restarts the time-out wait from zero.
- R10: A read while empty is ignored: the count stays 0 and nothing underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Engine clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Received word valid from the shifter |
| wr_data_i | input | 32 | Received word |
| rd_en_i | input | 1 | Software read pulse, pops the head word |
| rd_data_o | output | 32 | Head word |
| count_o | output | 4 | Number of stored words |
| full_o | output | 1 | Buffer holds 8 words |
| empty_o | output | 1 | Buffer holds no words |
| thr_level_i | input | 4 | Threshold level |
| thr_ie_i | input | 1 | Threshold interrupt enable |
| thr_flag_o | output | 1 | Count above threshold (live) |
| irq_o | output | 1 | Interrupt request |
| slave_mode_i | input | 1 | 0 = master time-out in ticks, 1 = slave time-out in cycles |
| sclk_tick_i | input | 1 | One-cycle serial-clock tick for master time-out |
| ovr_clr_i | input | 1 | Clear pulse for the overrun flag |
| to_clr_i | input | 1 | Clear pulse for the time-out flag |
| ovr_flag_o | output | 1 | Sticky overrun flag |
| to_flag_o | output | 1 | Sticky time-out flag |

## Verification
The assertions assume that reset is held low long enough to clear every register before the checks begin. They also assume that `rd_en_i`, `wr_en_i` and the clear pulses change only between clock edges, and that `slave_mode_i` stays fixed throughout a time-out wait. The stimulus drives every input one time unit after the rising edge, and it changes the mode only while the buffer is empty. This keeps the counter start unambiguous. The tick input is pulsed only in cycles with no write, so the master count is exact.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  typedef enum logic {
    TO_MASTER = 1'b0,
    TO_SLAVE  = 1'b1
  } to_mode_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_req_i,
  input  logic          pop_req_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          pop_o,
  output logic          drop_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          push;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign pop_o   = pop_req_i && !empty_o;
  // full buffer still takes the word if a pop frees a slot this cycle
  assign push    = push_req_i && (!full_o || pop_o);
  assign drop_o  = push_req_i && full_o && !pop_o;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push && (wr_ptr_q == PW'(g))) mem_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_o) rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      count_q <= count_q + CW'(push) - CW'(pop_o);
    end
  end

  assign rd_data_o = mem_q[rd_ptr_q];
  assign count_o   = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH)); // R2
  AST_DROP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> (count_q == $past(count_q))); // R5
  AST_FULL_RW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_req_i && pop_req_i) |=> full_o); // R6
  AST_EMPTY_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_req_i && !push_req_i) |=> empty_o); // R10
endmodule

// File: rtl/rx_fifo_timeout.sv
module rx_fifo_timeout
  import rx_fifo_pkg::*;
#(
  parameter int unsigned MST_LIMIT = 64,
  parameter int unsigned SLV_LIMIT = 576,
  localparam int unsigned MAXL     = max_u(MST_LIMIT, SLV_LIMIT),
  localparam int unsigned TW       = $clog2(MAXL + 1)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  to_mode_e mode_i,
  input  logic     tick_i,
  input  logic     empty_i,
  input  logic     pop_i,
  output logic     fire_o
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] last;
  logic          adv;

  assign last   = (mode_i == TO_SLAVE) ? TW'(SLV_LIMIT - 1) : TW'(MST_LIMIT - 1);
  assign adv    = !empty_i && !pop_i && ((mode_i == TO_SLAVE) || tick_i);
  assign fire_o = adv && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (empty_i || pop_i || fire_o) cnt_q <= '0;
    else if (adv) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < TW'(MAXL)); // R8
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i || empty_i) |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/rx_fifo_flags.sv
module rx_fifo_flags #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] thr_level_i,
  input  logic          thr_ie_i,
  input  logic          drop_i,
  input  logic          fire_i,
  input  logic          pop_i,
  input  logic          ovr_clr_i,
  input  logic          to_clr_i,
  output logic          thr_flag_o,
  output logic          irq_o,
  output logic          ovr_flag_o,
  output logic          to_flag_o
);
  logic ovr_q, to_q;

  assign thr_flag_o = (count_i > thr_level_i);
  assign irq_o      = thr_flag_o && thr_ie_i;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      if (drop_i) ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
      if (fire_i) to_q <= 1'b1;
      else if (pop_i || to_clr_i) to_q <= 1'b0;
    end
  end

  assign ovr_flag_o = ovr_q;
  assign to_flag_o  = to_q;

  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !ovr_clr_i) |=> ovr_q); // R5
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> ovr_q); // R5
  AST_TO_CLR_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |=> !to_q); // R9
endmodule

// File: rtl/rx_fifo_status.sv
module rx_fifo_status
  import rx_fifo_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned MST_LIMIT = 64,
  parameter int unsigned SLV_LIMIT = 576,
  localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  input  logic [CW-1:0] thr_level_i,
  input  logic          thr_ie_i,
  output logic          thr_flag_o,
  output logic          irq_o,
  input  logic          slave_mode_i,
  input  logic          sclk_tick_i,
  input  logic          ovr_clr_i,
  input  logic          to_clr_i,
  output logic          ovr_flag_o,
  output logic          to_flag_o
);
  logic     pop, drop, fire;
  to_mode_e mode;

  assign mode = slave_mode_i ? TO_SLAVE : TO_MASTER;

  rx_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_req_i(wr_en_i),
    .pop_req_i (rd_en_i),
    .wr_data_i,
    .rd_data_o,
    .count_o,
    .full_o,
    .empty_o,
    .pop_o     (pop),
    .drop_o    (drop)
  );

  rx_fifo_timeout #(.MST_LIMIT(MST_LIMIT), .SLV_LIMIT(SLV_LIMIT)) u_timeout (
    .clk_i, .rst_ni,
    .mode_i (mode),
    .tick_i (sclk_tick_i),
    .empty_i(empty_o),
    .pop_i  (pop),
    .fire_o (fire)
  );

  rx_fifo_flags #(.CW(CW)) u_flags (
    .clk_i, .rst_ni,
    .count_i    (count_o),
    .thr_level_i,
    .thr_ie_i,
    .drop_i     (drop),
    .fire_i     (fire),
    .pop_i      (pop),
    .ovr_clr_i,
    .to_clr_i,
    .thr_flag_o,
    .irq_o,
    .ovr_flag_o,
    .to_flag_o
  );

  AST_TO_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(to_flag_o) |-> $past(!empty_o)); // R7
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R2
endmodule

// File: tb/rx_fifo_status_tb.sv
module rx_fifo_status_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [3:0]  count_o, thr_level_i = 4'd3;
  logic        full_o, empty_o, thr_ie_i = 1'b0, thr_flag_o, irq_o;
  logic        slave_mode_i = 1'b0, sclk_tick_i = 1'b0;
  logic        ovr_clr_i = 1'b0, to_clr_i = 1'b0, ovr_flag_o, to_flag_o;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  bit done = 0;

  rx_fifo_status u_dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare head word against scoreboard on every read
  always @(negedge clk_i) begin
    if (rst_ni && rd_en_i && exp_q.size() > 0) chk("R2 data", rd_data_o, exp_q.pop_front());
  end

  task automatic op(bit wr, logic [31:0] d, bit rd, bit oc = 0, bit tc = 0);
    wr_en_i = wr; wr_data_i = d; rd_en_i = rd; ovr_clr_i = oc; to_clr_i = tc;
    @(negedge clk_i); #1;
    if (wr && (exp_q.size() < 8 || rd)) exp_q.push_back(d);
    @(posedge clk_i); #1;
    wr_en_i = 0; rd_en_i = 0; ovr_clr_i = 0; to_clr_i = 0;
  endtask

  task automatic idle(int n, bit tick = 0);
    sclk_tick_i = tick;
    repeat (n) @(posedge clk_i);
    #1 sclk_tick_i = 0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) op(0, 0, 1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    // R1
    chk("R1 count", count_o, 0); chk("R1 empty", empty_o, 1); chk("R1 full", full_o, 0);
    chk("R1 flags", {thr_flag_o, ovr_flag_o, to_flag_o, irq_o}, 0);
    // R10 read while empty
    op(0, 0, 1);
    chk("R10 count", count_o, 0); chk("R10 empty", empty_o, 1);
    // R2/R3/R4 threshold at 3
    for (int i = 0; i < 3; i++) op(1, 32'hA000_0000 + i, 0);
    chk("R2 count3", count_o, 3); chk("R3 eq thr", thr_flag_o, 0);
    op(1, 32'hA000_0003, 0);
    chk("R3 above thr", thr_flag_o, 1); chk("R4 irq ie0", irq_o, 0);
    thr_ie_i = 1; #1;
    chk("R4 irq ie1", irq_o, 1);
    for (int i = 4; i < 8; i++) op(1, 32'hA000_0000 + i, 0);
    chk("R2 full", full_o, 1); chk("R2 count8", count_o, 8); chk("R5 no ovr yet", ovr_flag_o, 0);
    // R5 overrun drop
    op(1, 32'hDEAD_0001, 0);
    chk("R5 ovr set", ovr_flag_o, 1); chk("R5 count held", count_o, 8);
    op(1, 32'hDEAD_0002, 0, 1);
    chk("R5 set wins", ovr_flag_o, 1);
    op(0, 0, 0, 1);
    chk("R5 w1c", ovr_flag_o, 0);
    // R6 simultaneous read/write while full
    op(1, 32'hB000_0000, 1);
    chk("R6 count", count_o, 8); chk("R6 no ovr", ovr_flag_o, 0);
    // drain, R3 live drop
    for (int i = 0; i < 5; i++) op(0, 0, 1);
    chk("R3 live", thr_flag_o, 0); chk("R4 irq low", irq_o, 0);
    drain();
    chk("R2 empty", empty_o, 1);
    // R7 master timeout
    op(1, 32'hC000_0001, 0);
    idle(10, 0);
    idle(63, 1);
    chk("R7 before", to_flag_o, 0);
    idle(1, 1);
    chk("R7 fire", to_flag_o, 1);
    op(0, 0, 0, 0, 1);
    chk("R9 w1c", to_flag_o, 0);
    drain();
    // R8 slave timeout
    slave_mode_i = 1;
    op(1, 32'hC000_0002, 0);
    op(1, 32'hC000_0003, 0);
    idle(574);
    chk("R8 before", to_flag_o, 0);
    idle(1);
    chk("R8 fire", to_flag_o, 1);
    // R9 read clears and restarts
    op(0, 0, 1);
    chk("R9 read clr", to_flag_o, 0);
    idle(575);
    chk("R9 restart", to_flag_o, 0);
    idle(1);
    chk("R9 refire", to_flag_o, 1);
    drain();
    chk("R9 empty", empty_o, 1);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule